// File: doc/BRIEF.md
# Row Command Packet Decoder

This block receives the three-wire row control lane of a packet-based DRAM device and turns it into decoded row commands. The lane carries one 3-bit sample per half-cycle of the interface clock. Here each sample arrives on one cycle of the block's own clock. Eight consecutive samples make one 24-bit packet. The first sample of a packet carries a framing pair on the two upper wires, and that pair also encodes the top bit of the target device address. The block finds packet starts, compares the device address with a programmable 5-bit device identifier, and recognises a broadcast code that addresses every device.

A matched packet is either an activate, which carries a 9-bit row and a 5-bit bank, or a row operation, which carries an 11-bit opcode. Several commands can share one opcode. The decoder raises a one-cycle strobe for each command it finds: activate, precharge, refresh-activate, refresh-precharge, power-down, nap, conditional nap, attention, relax and the two temperature-calibration commands. It also keeps the 9-bit refresh row counter that supplies the row address for refresh-activates.

Top module: `rowpkt_decoder`

## Requirements
- R1: While no packet is in progress, a sample starts a packet only if lane bit 2 or lane bit 1 is 1. That sample and the next seven form one packet. The search for a new start resumes with the sample that follows the eighth.
- R2: In the first sample, bit 2 is the true flag T and bit 1 is the false flag F. The device code is {dev_lo3, dev_lo2..0}, where dev_lo3 is bit 0 of the first sample and dev_lo2..0 are bits 2..0 of the second sample. With {T,F}=01 the packet matches when dev_id_i equals {0,dev_lo}. With 10 it matches when dev_id_i equals {1,dev_lo}. With 11 it always matches and bcast_o is 1. A packet that does not match produces no output.
- R3: For a matched packet, pkt_valid_o and the command strobes are high for exactly one cycle, in the cycle after the eighth sample is taken. At all other times they are 0.
- R4: Bank bits 0,1,2 are bits 2,1,0 of the third sample. Bank bits 3,4 are bits 2,1 of the fourth sample. Bit 0 of the fifth sample selects the packet type. When it is 1, act_o strobes, row_o is the concatenation of samples 6, 7 and 8 (each bits 2..0, most significant first), and attn_o also strobes unless the packet is a broadcast.
- R5: When the type bit is 0, the opcode op[10:0] is the concatenation of bits 2..1 of sample 5 and samples 6, 7 and 8 (bits 2..0 each), most significant first.
- R6: prer_o requires op[10:6]=11000 and op[2:0]=000. refa_o requires op[10:4]=0001100 and op[2:0]=000. refp_o requires op[10:4]=0101000 and op[2:0]=000.
- R7: When op[2:0]=000, op[8:4]=00001 gives pdnr_o, 00010 gives napr_o and 00011 gives naprc_o. op[3]=1 gives rlxr_o, and op[3]=0 gives attn_o.
- R8: tcal_o strobes only for op=00000000001, and tcen_o strobes only for op=00000000010.
- R9: One opcode can raise several strobes at once. For example, op=11000111000 raises prer_o, naprc_o and rlxr_o together.
- R10: ref_row_o resets to 0. A matched refresh-activate reports the current ref_row_o value on row_o. When its bank is 11111, the counter steps by one in the same cycle that the strobe appears, and it wraps from 511 to 0. No other packet changes the counter.
- R11: A broadcast packet never raises attn_o.
- R12: A matched row operation that no pattern covers (for example op[2:0]=100) raises pkt_valid_o and no command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one lane sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_lane_i | input | 3 | Row control lane sample |
| dev_id_i | input | 5 | Programmed device identifier |
| pkt_valid_o | output | 1 | Matched packet decoded (one-cycle pulse) |
| bcast_o | output | 1 | Decoded packet was a broadcast |
| act_o | output | 1 | Activate strobe |
| prer_o | output | 1 | Precharge strobe |
| refa_o | output | 1 | Refresh-activate strobe |
| refp_o | output | 1 | Refresh-precharge strobe |
| pdnr_o | output | 1 | Power-down request strobe |
| napr_o | output | 1 | Nap request strobe |
| naprc_o | output | 1 | Conditional nap request strobe |
| attn_o | output | 1 | Attention request strobe |
| rlxr_o | output | 1 | Relax request strobe |
| tcal_o | output | 1 | Temperature calibrate strobe |
| tcen_o | output | 1 | Temperature calibrate-enable strobe |
| bank_o | output | 5 | Bank of the decoded packet |
| row_o | output | 9 | Row for activate or refresh-activate |
| ref_row_o | output | 9 | Current refresh row counter |

## Verification
The assertions assume that the lane is sampled cleanly on every clock. They also assume that the controller never sends packets closer together than one packet length, so two matched packets can never land on adjacent decode cycles. The bench drives every packet as exactly eight samples and then holds the lane at zero for at least one cycle. It presents idle noise only on lane bit 0, which cannot frame a packet, so every frame it creates starts where it intends. The bench changes the device identifier only between packets, while the lane is idle.

// File: rtl/rowpkt_pkg.sv
package rowpkt_pkg;

    localparam int unsigned LANES  = 3;
    localparam int unsigned BEATS  = 8;
    localparam int unsigned ID_W   = 5;
    localparam int unsigned BANK_W = 5;
    localparam int unsigned ROW_W  = 9;
    localparam int unsigned OP_W   = 11;
    localparam int unsigned FRM_T  = 2;   // lane wire carrying the true flag
    localparam int unsigned FRM_F  = 1;   // lane wire carrying the false flag

    typedef logic [LANES-1:0] sample_t;

    typedef enum logic [1:0] {
        FRM_NONE  = 2'b00,
        FRM_LOW   = 2'b01,
        FRM_HIGH  = 2'b10,
        FRM_BCAST = 2'b11
    } frame_code_e;

    typedef struct packed {
        frame_code_e        frm;
        logic [ID_W-2:0]    dev_lo;
        logic [BANK_W-1:0]  bank;
        logic               av;
        logic [ROW_W-1:0]   row;
        logic [OP_W-1:0]    op;
    } rowpkt_t;

    typedef struct packed {
        logic act;
        logic prer;
        logic refa;
        logic refp;
        logic pdnr;
        logic napr;
        logic naprc;
        logic attn;
        logic rlxr;
        logic tcal;
        logic tcen;
    } rowcmd_t;

    // Field placement across the eight lane samples (sample 0 earliest).
    function automatic rowpkt_t unpack_pkt(input sample_t s0, input sample_t s1,
                                           input sample_t s2, input sample_t s3,
                                           input sample_t s4, input sample_t s5,
                                           input sample_t s6, input sample_t s7);
        rowpkt_t p;
        p.frm    = frame_code_e'({s0[FRM_T], s0[FRM_F]});
        p.dev_lo = {s0[0], s1};
        p.bank   = {s3[1], s3[2], s2[0], s2[1], s2[2]};
        p.av     = s4[0];
        p.row    = {s5, s6, s7};
        p.op     = {s4[2], s4[1], s5, s6, s7};
        return p;
    endfunction

    // Opcode to command strobes; fields that combine are tested separately.
    function automatic rowcmd_t decode_op(input logic [OP_W-1:0] op);
        rowcmd_t c;
        logic    base;
        base    = (op[2:0] == 3'b000);
        c       = '0;
        c.prer  = base && (op[10:6] == 5'b11000);
        c.refa  = base && (op[10:4] == 7'b0001100);
        c.refp  = base && (op[10:4] == 7'b0101000);
        c.pdnr  = base && (op[8:4] == 5'b00001);
        c.napr  = base && (op[8:4] == 5'b00010);
        c.naprc = base && (op[8:4] == 5'b00011);
        c.attn  = base && !op[3];
        c.rlxr  = base && op[3];
        c.tcal  = (op == 11'b00000000001);
        c.tcen  = (op == 11'b00000000010);
        return c;
    endfunction

endpackage

// File: rtl/rowpkt_deser.sv
module rowpkt_deser
    import rowpkt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sample_t lane_i,
    output logic    frame_done_o,
    output sample_t samples_o [BEATS]
);

    localparam int unsigned CNT_W = $clog2(BEATS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    sample_t          held_q [BEATS-1];
    logic             start;

    assign start        = !busy_q && (lane_i[FRM_T] || lane_i[FRM_F]);
    assign frame_done_o = busy_q && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(1);
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    for (genvar g = 0; g < BEATS - 1; g++) begin : g_beat
        logic take;
        if (g == 0) begin : g_first
            assign take = start;
        end else begin : g_rest
            assign take = busy_q && (cnt_q == CNT_W'(g));
        end
        always_ff @(posedge clk) begin
            if (rst) held_q[g] <= '0;
            else if (take) held_q[g] <= lane_i;
        end
        assign samples_o[g] = held_q[g];
    end

    assign samples_o[BEATS-1] = lane_i;

endmodule

// File: rtl/rowpkt_decode.sv
module rowpkt_decode
    import rowpkt_pkg::*;
(
    input  sample_t           samples_i [BEATS],
    input  logic [ID_W-1:0]   dev_id_i,
    input  logic [ROW_W-1:0]  ref_row_i,
    output logic              match_o,
    output logic              bcast_o,
    output rowcmd_t           cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o
);

    rowpkt_t pkt;
    rowcmd_t op_cmd;

    assign pkt = unpack_pkt(samples_i[0], samples_i[1], samples_i[2], samples_i[3],
                            samples_i[4], samples_i[5], samples_i[6], samples_i[7]);
    assign op_cmd = decode_op(pkt.op);

    always_comb begin
        unique case (pkt.frm)
            FRM_NONE:  match_o = 1'b0;
            FRM_LOW:   match_o = (dev_id_i == {1'b0, pkt.dev_lo});
            FRM_HIGH:  match_o = (dev_id_i == {1'b1, pkt.dev_lo});
            FRM_BCAST: match_o = 1'b1;
            default:   match_o = 1'b0;
        endcase
    end

    assign bcast_o = (pkt.frm == FRM_BCAST);
    assign bank_o  = pkt.bank;

    always_comb begin
        cmd_o = '0;
        row_o = '0;
        if (pkt.av) begin
            cmd_o.act  = 1'b1;
            cmd_o.attn = !bcast_o;
            row_o      = pkt.row;
        end else begin
            cmd_o      = op_cmd;
            cmd_o.attn = op_cmd.attn && !bcast_o;
            if (op_cmd.refa) row_o = ref_row_i;
        end
    end

endmodule

// File: rtl/rowpkt_refctr.sv
module rowpkt_refctr
    import rowpkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic [ROW_W-1:0] row_o
);

    always_ff @(posedge clk) begin
        if (rst) row_o <= '0;
        else if (inc_i) row_o <= row_o + ROW_W'(1);
    end

endmodule

// File: rtl/rowpkt_decoder.sv
module rowpkt_decoder
    import rowpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        row_lane_i,
    input  logic [4:0]        dev_id_i,
    output logic              pkt_valid_o,
    output logic              bcast_o,
    output logic              act_o,
    output logic              prer_o,
    output logic              refa_o,
    output logic              refp_o,
    output logic              pdnr_o,
    output logic              napr_o,
    output logic              naprc_o,
    output logic              attn_o,
    output logic              rlxr_o,
    output logic              tcal_o,
    output logic              tcen_o,
    output logic [4:0]        bank_o,
    output logic [8:0]        row_o,
    output logic [8:0]        ref_row_o
);

    localparam logic [BANK_W-1:0] LAST_BANK = '1;

    logic              frame_done;
    sample_t           samples [BEATS];
    logic              match, bcast;
    rowcmd_t           cmd;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic              ref_inc;
    logic              take;

    logic              valid_q, bcast_q;
    rowcmd_t           cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;

    rowpkt_deser u_deser (
        .clk          (clk),
        .rst          (rst),
        .lane_i       (row_lane_i),
        .frame_done_o (frame_done),
        .samples_o    (samples)
    );

    rowpkt_decode u_decode (
        .samples_i (samples),
        .dev_id_i  (dev_id_i),
        .ref_row_i (ref_row_o),
        .match_o   (match),
        .bcast_o   (bcast),
        .cmd_o     (cmd),
        .bank_o    (bank),
        .row_o     (row)
    );

    assign take    = frame_done && match;
    assign ref_inc = take && cmd.refa && (bank == LAST_BANK);

    rowpkt_refctr u_refctr (
        .clk   (clk),
        .rst   (rst),
        .inc_i (ref_inc),
        .row_o (ref_row_o)
    );

    always_ff @(posedge clk) begin
        if (rst || !take) begin
            valid_q <= 1'b0;
            bcast_q <= 1'b0;
            cmd_q   <= '0;
            bank_q  <= '0;
            row_q   <= '0;
        end else begin
            valid_q <= 1'b1;
            bcast_q <= bcast;
            cmd_q   <= cmd;
            bank_q  <= bank;
            row_q   <= row;
        end
    end

    assign pkt_valid_o = valid_q;
    assign bcast_o     = bcast_q;
    assign act_o       = cmd_q.act;
    assign prer_o      = cmd_q.prer;
    assign refa_o      = cmd_q.refa;
    assign refp_o      = cmd_q.refp;
    assign pdnr_o      = cmd_q.pdnr;
    assign napr_o      = cmd_q.napr;
    assign naprc_o     = cmd_q.naprc;
    assign attn_o      = cmd_q.attn;
    assign rlxr_o      = cmd_q.rlxr;
    assign tcal_o      = cmd_q.tcal;
    assign tcen_o      = cmd_q.tcen;
    assign bank_o      = bank_q;
    assign row_o       = row_q;

endmodule

// File: rtl/rowpkt_decoder_chk.sv
module rowpkt_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       pkt_valid_o,
    input logic       bcast_o,
    input logic       act_o,
    input logic       prer_o,
    input logic       refa_o,
    input logic       refp_o,
    input logic       pdnr_o,
    input logic       napr_o,
    input logic       naprc_o,
    input logic       attn_o,
    input logic       rlxr_o,
    input logic       tcal_o,
    input logic       tcen_o,
    input logic [4:0] bank_o,
    input logic [8:0] row_o,
    input logic [8:0] ref_row_o
);

    logic any_op;
    assign any_op = prer_o | refa_o | refp_o | pdnr_o | napr_o | naprc_o |
                    rlxr_o | tcal_o | tcen_o;

    // R3
    strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (any_op || act_o || attn_o || bcast_o) |-> pkt_valid_o);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |=> !pkt_valid_o);

    // R4
    act_alone_chk: assert property (@(posedge clk) disable iff (rst)
        act_o |-> !any_op);

    // R10
    ref_step_chk: assert property (@(posedge clk) disable iff (rst)
        (refa_o && bank_o == 5'h1f) |-> (ref_row_o == row_o + 9'd1));

    // R10
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_row_o != $past(ref_row_o)) |-> (refa_o && bank_o == 5'h1f));

    // R11
    bcast_no_attn_chk: assert property (@(posedge clk) disable iff (rst)
        attn_o |-> !bcast_o);

    // R7
    nap_kind_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pdnr_o, napr_o, naprc_o}));

endmodule

bind rowpkt_decoder rowpkt_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_valid_o (pkt_valid_o),
    .bcast_o     (bcast_o),
    .act_o       (act_o),
    .prer_o      (prer_o),
    .refa_o      (refa_o),
    .refp_o      (refp_o),
    .pdnr_o      (pdnr_o),
    .napr_o      (napr_o),
    .naprc_o     (naprc_o),
    .attn_o      (attn_o),
    .rlxr_o      (rlxr_o),
    .tcal_o      (tcal_o),
    .tcen_o      (tcen_o),
    .bank_o      (bank_o),
    .row_o       (row_o),
    .ref_row_o   (ref_row_o)
);

// File: tb/rowpkt_decoder_bench.sv
module rowpkt_decoder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] lane = 3'b000;
    logic [4:0] dev_id = 5'h0B;
    logic       pkt_valid, bcast, act, prer, refa, refp, pdnr, napr, naprc;
    logic       attn, rlxr, tcal, tcen;
    logic [4:0] bank;
    logic [8:0] row, ref_row;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_ref = 9'd0;

    always #2.5 clk = ~clk;

    rowpkt_decoder u_rowpkt_decoder (
        .clk(clk), .rst(rst), .row_lane_i(lane), .dev_id_i(dev_id),
        .pkt_valid_o(pkt_valid), .bcast_o(bcast), .act_o(act), .prer_o(prer),
        .refa_o(refa), .refp_o(refp), .pdnr_o(pdnr), .napr_o(napr),
        .naprc_o(naprc), .attn_o(attn), .rlxr_o(rlxr), .tcal_o(tcal),
        .tcen_o(tcen), .bank_o(bank), .row_o(row), .ref_row_o(ref_row)
    );

    // {valid,bcast,act,prer,refa,refp,pdnr,napr,naprc,attn,rlxr,tcal,tcen}
    function automatic logic [12:0] got_flags();
        return {pkt_valid, bcast, act, prer, refa, refp, pdnr, napr, naprc,
                attn, rlxr, tcal, tcen};
    endfunction

    function automatic logic [12:0] want_flags(input logic m, input logic b,
                                               input logic av, input logic [10:0] op);
        logic [12:0] f;
        logic z;
        f = '0;
        if (!m) return f;
        f[12] = 1'b1;
        f[11] = b;
        if (av) begin
            f[10] = 1'b1;
            f[3]  = !b;
            return f;
        end
        z = (op[2:0] == 3'b000);
        f[9] = z && op[10:6] == 5'b11000;
        f[8] = z && op[10:4] == 7'b0001100;
        f[7] = z && op[10:4] == 7'b0101000;
        f[6] = z && op[8:4] == 5'b00001;
        f[5] = z && op[8:4] == 5'b00010;
        f[4] = z && op[8:4] == 5'b00011;
        f[3] = z && !op[3] && !b;
        f[2] = z && op[3];
        f[1] = (op == 11'b00000000001);
        f[0] = (op == 11'b00000000010);
        return f;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, want);
        end
    endtask

    // Serialise one packet, then check the decode cycle and the cycle after.
    task automatic run_pkt(input string req, input logic t, input logic f,
                           input logic [3:0] dv, input logic [4:0] bk,
                           input logic av, input logic [10:0] pay);
        logic [2:0] s [8];
        logic m, b;
        logic [12:0] wf;
        logic [8:0] wrow;
        s[0] = {t, f, dv[3]};
        s[1] = dv[2:0];
        s[2] = {bk[0], bk[1], bk[2]};
        s[3] = {bk[3], bk[4], 1'b0};
        s[4] = {pay[10], pay[9], av};
        s[5] = pay[8:6];
        s[6] = pay[5:3];
        s[7] = pay[2:0];
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) lane = s[i];
        end
        @(negedge clk) lane = 3'b000;
        b = t & f;
        m = b || ((t | f) && dev_id == {t, dv});
        wf = want_flags(m, b, av, pay);
        wrow = !m ? 9'd0 : av ? pay[8:0] : wf[8] ? exp_ref : 9'd0;
        chk(req, "flags", 32'(got_flags()), 32'(wf));
        chk(req, "bank", 32'(bank), m ? 32'(bk) : 32'd0);
        chk(req, "row", 32'(row), 32'(wrow));
        if (wf[8] && bk == 5'h1f) exp_ref = exp_ref + 9'd1;
        chk("R10", "ref_row", 32'(ref_row), 32'(exp_ref));
        @(negedge clk);
        chk("R3", "pulse end", 32'(got_flags()), 32'd0);
    endtask

    task automatic t_reset();
        chk("R10", "reset ref_row", 32'(ref_row), 32'd0);
        chk("R3", "reset flags", 32'(got_flags()), 32'd0);
        chk("R3", "reset row", 32'(row), 32'd0);
    endtask

    task automatic t_activate();
        run_pkt("R4", 1'b0, 1'b1, 4'hB, 5'd7, 1'b1, {2'b00, 9'h1A5});
        run_pkt("R4", 1'b0, 1'b1, 4'hB, 5'd22, 1'b1, {2'b00, 9'h05A});
    endtask

    task automatic t_match();
        run_pkt("R2", 1'b0, 1'b1, 4'hA, 5'd1, 1'b1, {2'b00, 9'h0FF});
        run_pkt("R2", 1'b1, 1'b0, 4'hB, 5'd1, 1'b1, {2'b00, 9'h0FF});
        dev_id = 5'h1B;
        run_pkt("R2", 1'b1, 1'b0, 4'hB, 5'd9, 1'b1, {2'b00, 9'h133});
        run_pkt("R2", 1'b0, 1'b1, 4'hB, 5'd9, 1'b1, {2'b00, 9'h133});
        dev_id = 5'h0B;
    endtask

    task automatic t_broadcast();
        run_pkt("R11", 1'b1, 1'b1, 4'h3, 5'd4, 1'b0, 11'b11000000000);
        run_pkt("R11", 1'b1, 1'b1, 4'h0, 5'd4, 1'b1, {2'b00, 9'h011});
    endtask

    task automatic t_ops();
        run_pkt("R6", 1'b0, 1'b1, 4'hB, 5'd12, 1'b0, 11'b11000000000);
        run_pkt("R6", 1'b0, 1'b1, 4'hB, 5'd12, 1'b0, 11'b01010000000);
        run_pkt("R7", 1'b0, 1'b1, 4'hB, 5'd0, 1'b0, 11'b00000010000);
        run_pkt("R7", 1'b0, 1'b1, 4'hB, 5'd0, 1'b0, 11'b11000101000);
        run_pkt("R7", 1'b0, 1'b1, 4'hB, 5'd0, 1'b0, 11'b00000001000);
        run_pkt("R8", 1'b0, 1'b1, 4'hB, 5'd0, 1'b0, 11'b00000000001);
        run_pkt("R8", 1'b0, 1'b1, 4'hB, 5'd0, 1'b0, 11'b00000000010);
        run_pkt("R5", 1'b0, 1'b1, 4'hB, 5'd0, 1'b0, 11'b00000000000);
    endtask

    task automatic t_combined();
        run_pkt("R9", 1'b0, 1'b1, 4'hB, 5'd18, 1'b0, 11'b11000111000);
    endtask

    task automatic t_reserved();
        run_pkt("R12", 1'b0, 1'b1, 4'hB, 5'd3, 1'b0, 11'b11000000100);
        run_pkt("R12", 1'b0, 1'b1, 4'hB, 5'd3, 1'b0, 11'b10000000001);
    endtask

    task automatic t_refresh();
        run_pkt("R10", 1'b0, 1'b1, 4'hB, 5'd3, 1'b0, 11'b00011000000);
        run_pkt("R10", 1'b0, 1'b1, 4'hB, 5'd31, 1'b0, 11'b00011000000);
        run_pkt("R10", 1'b0, 1'b1, 4'hB, 5'd31, 1'b0, 11'b00011001000);
        run_pkt("R10", 1'b0, 1'b1, 4'hA, 5'd31, 1'b0, 11'b00011000000);
    endtask

    task automatic t_noframe();
        for (int i = 0; i < 11; i++) begin
            @(negedge clk) lane = 3'b001;
            chk("R1", "no frame", 32'(pkt_valid), 32'd0);
        end
        @(negedge clk) lane = 3'b000;
        run_pkt("R1", 1'b0, 1'b1, 4'hB, 5'd5, 1'b1, {2'b00, 9'h0C3});
    endtask

    task automatic t_wrap();
        while (exp_ref != 9'd511)
            run_pkt("R10", 1'b1, 1'b1, 4'h0, 5'd31, 1'b0, 11'b00011000000);
        run_pkt("R10", 1'b1, 1'b1, 4'h0, 5'd31, 1'b0, 11'b00011000000);
        chk("R10", "wrap", 32'(ref_row), 32'd0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_activate();
        t_match();
        t_broadcast();
        t_ops();
        t_combined();
        t_reserved();
        t_refresh();
        t_noframe();
        t_wrap();
        finish_run();
    end

endmodule